// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

A first-in first-out buffer that carries 36-bit words from a write clock domain to a read clock domain. The two clocks may be unrelated. Each side qualifies a transfer with an active-low select and an active-high enable. The write side is a valid/ready stream: valid is `!wr_cs_n && wr_en`, and ready is the write status flag read in the current mode. A write offered while the buffer cannot take it is dropped. The producer must hold its word until it sees ready, and the block never stalls the producer in any other way. The read side works the same way: a read offered while no word is available is ignored and has no effect.

The block exchanges its pointers between the two domains as Gray code through synchronizer chains. Two level flags compare against offsets that another block loads: `off_x` for almost-empty and `off_y` for almost-full. The `std_mode` input picks the timing mode, and it must stay fixed from reset onward. In standard mode a read strobe fetches a word, and the word appears one read clock later. In fall-through mode the oldest word is already on `rd_data` before any strobe, and a read moves on to the next word. The two status flags change their meaning with the mode.

Top module: `xclk_flag_fifo`

## Requirements
- R1: A word moves only on a rising edge of its port's clock while that port's select is low (0) and its enable is high (1). Cycles with select high, or with enable low, leave the buffer unchanged.
- R2: Words leave in the order they were accepted, with their value unchanged.
- R3: When `std_mode`=1, `rd_stat`=1 means no word is readable. A read accepted on a `rclk` edge places the word on `rd_data` after that edge. `rd_stat` returns to 1 after the edge that takes the last word.
- R4: When `std_mode`=1, `wr_stat`=1 means full: 2^ADDR_W words are held. Writes offered while full are dropped.
- R5: When `std_mode`=0, `rd_stat`=1 means a valid word is on `rd_data` without any strobe, and a read replaces it with the next word. `wr_stat`=1 means space is free. The buffer holds 2^ADDR_W+1 words, the extra one being the word on the output.
- R6: `rd_aempty_n` is 0 exactly when the stored word count is no greater than `off_x`. It is computed in the `rclk` domain. When `std_mode`=0, the count includes the word on the output.
- R7: `wr_afull_n` is 0 exactly when the free memory locations number no more than `off_y`. It is computed in the `wclk` domain. In fall-through mode, the word moved to the output no longer occupies memory.
- R8: `rd_oe` is 1 exactly when `rd_cs_n` is 0.
- R9: After reset the buffer is empty. With `std_mode`=1 the flags are `rd_stat`=1 and `wr_stat`=0. With `std_mode`=0 they are `rd_stat`=0 and `wr_stat`=1. In both modes `rd_aempty_n`=0, and `wr_afull_n`=1 when `off_y` < 2^ADDR_W.
- R10: A word written into an empty buffer becomes visible on the read side by the third rising `rclk` edge after its write edge. In standard mode this means `rd_stat`=0. In fall-through mode it means `rd_stat`=1 with the word on `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| std_mode | input | 1 | 1 selects standard mode, 0 selects fall-through; static after reset |
| wr_cs_n | input | 1 | Write select, active low |
| wr_en | input | 1 | Write enable, active high |
| wr_data | input | DATA_W | Word to write |
| wr_stat | output | 1 | Full (standard mode) or input ready (fall-through mode) |
| wr_afull_n | output | 1 | Almost-full, active low |
| off_y | input | ADDR_W+1 | Almost-full offset |
| rd_cs_n | input | 1 | Read select, active low |
| rd_en | input | 1 | Read enable, active high |
| rd_data | output | DATA_W | Read word |
| rd_stat | output | 1 | Empty (standard mode) or output ready (fall-through mode) |
| rd_aempty_n | output | 1 | Almost-empty, active low |
| rd_oe | output | 1 | Output enable, standing in for a tri-state driver |
| off_x | input | ADDR_W+1 | Almost-empty offset |

## Verification
The bench builds the block with ADDR_W=4, a 16-word memory, and keeps DATA_W=36. At that depth the full and input-ready boundaries, and the extra output slot in fall-through mode, are reached within a few dozen cycles. The offsets can also be swept over every value from 0 to 16 at several fill levels. The two clocks share a period but run out of phase, so each write crosses the synchronizers at a fixed offset. This keeps the latency bound checkable, while random traffic still interleaves the domains.

// File: rtl/xclk_flag_fifo_pkg.sv
package xclk_flag_fifo_pkg;
  typedef enum logic {
    MODE_FALL = 1'b0,
    MODE_STD  = 1'b1
  } fifo_mode_e;
endpackage

// File: rtl/xclk_gray_sync.sv
module xclk_gray_sync #(
  parameter int unsigned W      = 11,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [STAGES-1:0][W-1:0] stg;
  logic [W-1:0]             gq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '0;
    else        stg <= {stg[STAGES-2:0], gray_in};
  end

  assign gq = stg[STAGES-1];

  for (genvar i = 0; i < W; i++) begin : g_bin
    assign bin_out[i] = ^gq[W-1:i];
  end

  // R10
  gray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gq ^ $past(gq)) <= 1);
endmodule

// File: rtl/xclk_dp_ram.sv
module xclk_dp_ram #(
  parameter int unsigned DW = 36,
  parameter int unsigned AW = 10
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/xclk_wr_ctl.sv
module xclk_wr_ctl #(
  parameter int unsigned AW = 10
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          std_mode,
  input  logic          cs_n,
  input  logic          en,
  input  logic [AW:0]   rsync_bin,
  input  logic [AW:0]   off_y,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wptr_gray,
  output logic          wr_stat,
  output logic          afull_n
);
  localparam logic [AW:0] DEPTH_V = {1'b1, {AW{1'b0}}};

  logic [AW:0] wbin, wnext, wcount, wfree;
  logic        full;

  assign wcount  = wbin - rsync_bin;
  assign full    = (wcount == DEPTH_V);
  assign wfree   = DEPTH_V - wcount;
  assign afull_n = !(wfree <= off_y);
  assign wr_stat = std_mode ? full : !full;
  assign we      = !cs_n && en && !full;
  assign waddr   = wbin[AW-1:0];
  assign wnext   = wbin + 1'b1;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin      <= '0;
      wptr_gray <= '0;
    end else if (we) begin
      wbin      <= wnext;
      wptr_gray <= wnext ^ (wnext >> 1);
    end
  end

  // R4
  no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    wcount <= DEPTH_V);
  // R4
  full_hold_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    full |=> $stable(wbin));
endmodule

// File: rtl/xclk_rd_ctl.sv
module xclk_rd_ctl #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 36
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          std_mode,
  input  logic          cs_n,
  input  logic          en,
  input  logic [AW:0]   wsync_bin,
  input  logic [AW:0]   off_x,
  input  logic [DW-1:0] rdata,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rptr_gray,
  output logic          rd_stat,
  output logic          aempty_n
);
  logic [AW:0]   rbin, rnext, mem_cnt;
  logic [AW+1:0] rcount;
  logic          ov, mem_empty, req, pop, fetch;

  assign mem_empty = (wsync_bin == rbin);
  assign req       = !cs_n && en;
  assign pop       = req && ov;
  assign fetch     = std_mode ? (req && !mem_empty) : (!mem_empty && (!ov || pop));
  assign re        = fetch;
  assign raddr     = rbin[AW-1:0];
  assign rnext     = rbin + 1'b1;
  assign mem_cnt   = wsync_bin - rbin;
  assign rcount    = {1'b0, mem_cnt} + (AW+2)'(!std_mode && ov);
  assign aempty_n  = !(rcount <= {1'b0, off_x});
  assign rd_stat   = std_mode ? mem_empty : ov;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin      <= '0;
      rptr_gray <= '0;
      ov        <= 1'b0;
    end else begin
      if (fetch) begin
        rbin      <= rnext;
        rptr_gray <= rnext ^ (rnext >> 1);
      end
      if (fetch)    ov <= 1'b1;
      else if (pop) ov <= 1'b0;
    end
  end

  // R3
  empty_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (std_mode && mem_empty) |=> $stable(rbin));
  // R5
  fall_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (!std_mode && ov && !req) |=> (ov && $stable(rdata)));
  // R5
  fall_fill_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (!std_mode && !ov && !mem_empty) |=> ov);
endmodule

// File: rtl/xclk_flag_fifo.sv
module xclk_flag_fifo
  import xclk_flag_fifo_pkg::*;
#(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned ADDR_W = 10
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              std_mode,
  input  logic              wr_cs_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_stat,
  output logic              wr_afull_n,
  input  logic [ADDR_W:0]   off_y,
  input  logic              rd_cs_n,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_stat,
  output logic              rd_aempty_n,
  output logic              rd_oe,
  input  logic [ADDR_W:0]   off_x
);
  localparam int unsigned PW = ADDR_W + 1;

  fifo_mode_e        mode;
  logic              is_std, we, re;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [PW-1:0]     wptr_gray, rptr_gray, wsync_bin, rsync_bin;

  assign mode   = fifo_mode_e'(std_mode);
  assign is_std = (mode == MODE_STD);
  assign rd_oe  = !rd_cs_n;

  xclk_wr_ctl #(.AW(ADDR_W)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .std_mode(is_std), .cs_n(wr_cs_n), .en(wr_en),
    .rsync_bin(rsync_bin), .off_y(off_y), .we(we), .waddr(waddr),
    .wptr_gray(wptr_gray), .wr_stat(wr_stat), .afull_n(wr_afull_n)
  );

  xclk_rd_ctl #(.AW(ADDR_W), .DW(DATA_W)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .std_mode(is_std), .cs_n(rd_cs_n), .en(rd_en),
    .wsync_bin(wsync_bin), .off_x(off_x), .rdata(rd_data), .re(re),
    .raddr(raddr), .rptr_gray(rptr_gray), .rd_stat(rd_stat), .aempty_n(rd_aempty_n)
  );

  xclk_gray_sync #(.W(PW), .STAGES(2)) u_wsync (
    .clk(rclk), .rst_n(rst_n), .gray_in(wptr_gray), .bin_out(wsync_bin)
  );

  xclk_gray_sync #(.W(PW), .STAGES(2)) u_rsync (
    .clk(wclk), .rst_n(rst_n), .gray_in(rptr_gray), .bin_out(rsync_bin)
  );

  xclk_dp_ram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
    .wclk(wclk), .we(we), .waddr(waddr), .wdata(wr_data),
    .rclk(rclk), .rst_n(rst_n), .re(re), .raddr(raddr), .rdata(rd_data)
  );
endmodule

// File: tb/xclk_flag_fifo_bench.sv
module xclk_flag_fifo_bench;
  localparam int DW = 36;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0, std_mode = 1'b1;
  logic wr_cs_n = 1'b1, wr_en = 1'b0, rd_cs_n = 1'b1, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [AW:0] off_x = 5'd3, off_y = 5'd2;
  logic wr_stat, wr_afull_n, rd_stat, rd_aempty_n, rd_oe;

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] q[$];

  always #4 wclk = ~wclk;
  initial begin #3; forever #4 rclk = ~rclk; end

  xclk_flag_fifo #(.DATA_W(DW), .ADDR_W(AW)) u_xclk_flag_fifo (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .std_mode(std_mode),
    .wr_cs_n(wr_cs_n), .wr_en(wr_en), .wr_data(wr_data), .wr_stat(wr_stat),
    .wr_afull_n(wr_afull_n), .off_y(off_y), .rd_cs_n(rd_cs_n), .rd_en(rd_en),
    .rd_data(rd_data), .rd_stat(rd_stat), .rd_aempty_n(rd_aempty_n),
    .rd_oe(rd_oe), .off_x(off_x)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit can_write();
    return std_mode ? !wr_stat : wr_stat;
  endfunction

  function automatic int mem_count(input int cnt);
    if (std_mode) return cnt;
    return (cnt > 0) ? cnt - 1 : 0;
  endfunction

  task automatic do_reset(input logic mode);
    rst_n = 1'b0; std_mode = mode;
    wr_cs_n = 1'b1; wr_en = 1'b0; rd_cs_n = 1'b1; rd_en = 1'b0;
    repeat (3) @(posedge wclk);
    @(negedge wclk); rst_n = 1'b1;
    q.delete();
    repeat (2) @(negedge rclk);
  endtask

  task automatic wr_burst(input int n, input int pct);
    for (int i = 0; i < n; i++) begin
      bit go;
      logic [DW-1:0] d;
      @(negedge wclk);
      go = ($urandom_range(99) < pct);
      d = DW'({$urandom(), $urandom()});
      if (go) begin wr_cs_n = 1'b0; wr_en = 1'b1; end
      else if ($urandom_range(1) == 1) begin wr_cs_n = 1'b1; wr_en = 1'b1; end
      else begin wr_cs_n = 1'b0; wr_en = 1'b0; end
      wr_data = d;
      if (go && can_write()) q.push_back(d);
    end
    @(negedge wclk); wr_cs_n = 1'b1; wr_en = 1'b0;
  endtask

  task automatic rd_burst(input int n, input int pct);
    bit pend = 1'b0;
    logic [DW-1:0] expv = '0;
    for (int i = 0; i < n; i++) begin
      bit go;
      @(negedge rclk);
      if (pend) begin chk(rd_data == expv, "R3", 64'(rd_data), 64'(expv)); pend = 1'b0; end
      go = ($urandom_range(99) < pct);
      if (go) begin rd_cs_n = 1'b0; rd_en = 1'b1; end
      else if ($urandom_range(1) == 1) begin rd_cs_n = 1'b1; rd_en = 1'b1; end
      else begin rd_cs_n = 1'b0; rd_en = 1'b0; end
      if (std_mode) begin
        if (go && !rd_stat) begin
          if (q.size() == 0) chk(1'b0, "R2", 64'(rd_stat), 64'd1);
          else begin expv = q.pop_front(); pend = 1'b1; end
        end
      end else if (rd_stat) begin
        if (q.size() == 0) chk(1'b0, "R2", 64'(rd_stat), 64'd0);
        else begin
          chk(rd_data == q[0], "R5", 64'(rd_data), 64'(q[0]));
          if (go) void'(q.pop_front());
        end
      end
      #1 chk(rd_oe == !rd_cs_n, "R8", 64'(rd_oe), 64'(!rd_cs_n));
    end
    @(negedge rclk);
    if (pend) chk(rd_data == expv, "R3", 64'(rd_data), 64'(expv));
    rd_cs_n = 1'b1; rd_en = 1'b0;
  endtask

  task automatic flag_chk();
    int cnt, mc;
    repeat (6) @(negedge rclk);
    cnt = q.size();
    mc = mem_count(cnt);
    if (std_mode) chk(rd_stat == (cnt == 0), "R3", 64'(rd_stat), 64'(cnt == 0));
    else          chk(rd_stat == (cnt > 0), "R5", 64'(rd_stat), 64'(cnt > 0));
    chk(rd_aempty_n == !(cnt <= int'(off_x)), "R6", 64'(rd_aempty_n), 64'(!(cnt <= int'(off_x))));
    @(negedge wclk);
    chk(wr_afull_n == !((DEPTH - mc) <= int'(off_y)), "R7", 64'(wr_afull_n),
        64'(!((DEPTH - mc) <= int'(off_y))));
    if (std_mode) chk(wr_stat == (mc == DEPTH), "R4", 64'(wr_stat), 64'(mc == DEPTH));
    else          chk(wr_stat == (mc != DEPTH), "R5", 64'(wr_stat), 64'(mc != DEPTH));
  endtask

  task automatic offset_sweep();
    int cnt, mc;
    cnt = q.size();
    mc = mem_count(cnt);
    for (int v = 0; v <= DEPTH; v++) begin
      off_x = (AW+1)'(v); off_y = (AW+1)'(v);
      @(negedge wclk);
      chk(wr_afull_n == !((DEPTH - mc) <= v), "R7", 64'(wr_afull_n), 64'(!((DEPTH - mc) <= v)));
      @(negedge rclk);
      chk(rd_aempty_n == !(cnt <= v), "R6", 64'(rd_aempty_n), 64'(!(cnt <= v)));
    end
  endtask

  task automatic single_latency();
    logic [DW-1:0] d;
    d = DW'({$urandom(), $urandom()});
    @(negedge wclk);
    wr_cs_n = 1'b0; wr_en = 1'b1; wr_data = d;
    if (can_write()) q.push_back(d);
    @(posedge wclk);
    #1 wr_cs_n = 1'b1; wr_en = 1'b0;
    repeat (3) @(posedge rclk);
    #1;
    chk(rd_stat == !std_mode, "R10", 64'(rd_stat), 64'(!std_mode));
    if (!std_mode) chk(rd_data == d, "R5", 64'(rd_data), 64'(d));
  endtask

  task automatic run_mode(input logic mode);
    do_reset(mode);
    off_x = 5'd3; off_y = 5'd2;
    // R9 reset state
    chk(rd_stat == mode, "R9", 64'(rd_stat), 64'(mode));
    chk(wr_stat == !mode, "R9", 64'(wr_stat), 64'(!mode));
    chk(rd_aempty_n == 1'b0, "R9", 64'(rd_aempty_n), 64'd0);
    chk(wr_afull_n == 1'b1, "R9", 64'(wr_afull_n), 64'd1);
    // R8 output enable follows select
    rd_cs_n = 1'b1; #1 chk(rd_oe == 1'b0, "R8", 64'(rd_oe), 64'd0);
    rd_cs_n = 1'b0; #1 chk(rd_oe == 1'b1, "R8", 64'(rd_oe), 64'd1);
    rd_cs_n = 1'b1;
    // R1 unqualified write cycles leave the buffer empty
    @(negedge wclk); wr_cs_n = 1'b1; wr_en = 1'b1;
    repeat (4) @(negedge wclk);
    wr_cs_n = 1'b0; wr_en = 1'b0;
    repeat (4) @(negedge wclk);
    wr_cs_n = 1'b1;
    repeat (6) @(negedge rclk);
    chk(rd_stat == mode, "R1", 64'(rd_stat), 64'(mode));
    single_latency();
    rd_burst(6, 100);
    flag_chk();
    for (int r = 0; r < 4; r++) begin
      off_x = (AW+1)'($urandom_range(DEPTH));
      off_y = (AW+1)'($urandom_range(DEPTH));
      fork
        wr_burst(250, int'($urandom_range(30, 90)));
        rd_burst(250, int'($urandom_range(30, 90)));
      join
      flag_chk();
      offset_sweep();
    end
    off_x = 5'd3; off_y = 5'd2;
    rd_burst(3 * DEPTH, 100);
    flag_chk();
    wr_burst(DEPTH + 5, 100);
    chk(q.size() == (mode ? DEPTH : DEPTH + 1), mode ? "R4" : "R5",
        64'(q.size()), 64'(mode ? DEPTH : DEPTH + 1));
    flag_chk();
    offset_sweep();
    off_x = 5'd3; off_y = 5'd2;
    rd_burst(3 * DEPTH, 100);
    flag_chk();
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    run_mode(1'b1);
    run_mode(1'b0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule